// File: doc/BRIEF.md
# I2S Master Serial Audio Transmitter

This block takes stereo sample pairs from a small internal queue and shifts them out as a serial audio stream. It is the clock master and derives the bit clock and word select from the system clock through an even divider. Each channel slot carries one 24-bit sample in a 24-clock or a 32-clock slot. When the slot is 32 clocks long, the eight padding zeros sit either before the sample or after it.

Static controls set the word-select polarity, the bit order and the slot format. Another control selects mono output: the sample goes into one chosen slot, and the other slot carries either a copy of that sample or a programmable fill word. A halt control chooses what happens when the queue runs dry at a frame boundary. With halt set, the clocks freeze until a new pair arrives. With halt clear, an all-zero frame is sent instead. A start input gates all activity, and a synchronous reset returns the counters, the shifter and the queue to idle.

Top module: `i2s_serial_tx`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `bclk` and `sd` are 0, `ws` is at the left-channel level and `fifo_full` is 0. The queue is emptied, so pairs written before reset are never sent.
- R2: The left-channel level of `ws` equals `ws_invert`, and the right-channel level is its inverse.
- R3: `sd` and `ws` change only while `bclk` is low, so a receiver samples them on rising `bclk` edges. `ws` switches to the next channel's level during the last bit of the current slot.
- R4: With `lsb_first` at 0, sample bit 23 is sent first and bit 0 last. With `lsb_first` at 1, the order is reversed.
- R5: With `wide_slot` at 0, each slot lasts 24 bit clocks. With `wide_slot` at 1, each slot lasts 32 bit clocks.
- R6: In a 32-clock slot with `left_justify` at 1, the 24 sample bits come first and are followed by 8 zeros. With `left_justify` at 0, 8 zeros come first and the sample follows.
- R7: With `mono_en` at 1, the entry's `wr_left` value is the sample and `wr_right` is ignored. The sample goes into the left slot when `mono_first` is 1 and into the right slot when it is 0.
- R8: In mono mode, the other slot carries the same sample when `mono_dup` is 1, and carries `mono_fill` when `mono_dup` is 0.
- R9: With `halt_on_empty` at 1, if the queue is empty when a frame would begin, `bclk` holds low and `ws` holds the left level. Output resumes with the left slot of the next pair once one is written.
- R10: With `halt_on_empty` at 0, an empty queue at a frame boundary produces one all-zero frame. The clocks keep running and no entry is consumed.
- R11: A pair is removed from the queue only as its left slot begins, and never while the queue is empty.
- R12: `fifo_full` is 1 when FIFO_DEPTH pairs are held. A write while full is dropped, and that pair never appears on `sd`.
- R13: With `start` at 0, `bclk` stays low. Deasserting `start` mid-frame returns the block to idle within one cycle.
- R14: The `bclk` period is CLK_DIV system clocks, with CLK_DIV/2 cycles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high transmitter reset |
| start | input | 1 | Enables transmission while high |
| ws_invert | input | 1 | Word-select level during the left slot |
| lsb_first | input | 1 | 1 sends sample LSB first |
| left_justify | input | 1 | 1 places padding after the sample in 32-clock slots |
| wide_slot | input | 1 | 1 selects 32-clock slots, 0 selects 24-clock slots |
| mono_en | input | 1 | Mono output mode |
| mono_first | input | 1 | Mono sample goes into the left slot when 1 |
| mono_dup | input | 1 | Mono: other slot repeats the sample when 1 |
| halt_on_empty | input | 1 | Freeze clocks when the queue is empty at a frame boundary |
| mono_fill | input | 24 | Word placed in the non-sample slot in mono mode |
| wr_en | input | 1 | Writes one pair into the queue |
| wr_left | input | 24 | Left sample (the mono sample in mono mode) |
| wr_right | input | 24 | Right sample |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH pairs |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |

## Verification
The bench decodes the stream at rising `bclk` edges and compares every bit of word select and data against a model. It checks each polarity, bit order and justification, so a lagging `ws` or misplaced padding shows up as a flipped bit at a slot edge. It stalls the stream on an empty queue and then resumes it, so a design that pops mid-frame or lets `bclk` run on would misalign the left and right samples or emit unexpected bits. It also overfills the queue, resets it with data inside, and runs dry with the halt control off. A design that let overflow data through, kept data across reset, or consumed an entry for the zero frame would produce extra frames or missing frames.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int PAD_W    = 8;
    localparam int WIDE_W   = SAMPLE_W + PAD_W;
    localparam int IDX_W    = $clog2(WIDE_W);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [IDX_W-1:0]    idx_t;

    typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    typedef struct packed {
        logic ws_invert;
        logic lsb_first;
        logic left_justify;
        logic wide_slot;
        logic mono_en;
        logic mono_first;
        logic mono_dup;
        logic halt_on_empty;
    } cfg_t;

    function automatic idx_t last_idx(input logic wide);
        return wide ? idx_t'(WIDE_W - 1) : idx_t'(SAMPLE_W - 1);
    endfunction

    function automatic chan_e other_chan(input chan_e ch);
        return (ch == CH_LEFT) ? CH_RIGHT : CH_LEFT;
    endfunction

    function automatic logic ws_level(input chan_e ch, input logic inv);
        return (ch == CH_RIGHT) ^ inv;
    endfunction

    // Bit sent at slot position idx for sample s under the given format.
    function automatic logic slot_bit(input sample_t s, input idx_t idx, input cfg_t c);
        int   k;
        logic pad;
        k   = int'(idx);
        pad = 1'b0;
        if (c.wide_slot) begin
            if (c.left_justify) begin
                pad = (k >= SAMPLE_W);
            end else begin
                pad = (k < PAD_W);
                k   = k - PAD_W;
            end
        end
        if (pad) return 1'b0;
        if (c.lsb_first) return s[k];
        return s[SAMPLE_W-1-k];
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int WIDTH = 48,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    count;
    logic             do_wr, do_rd;

    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
    import i2s_tx_pkg::*;
(
    input  cfg_t    cfg,
    input  logic    have_data,
    input  pair_t   head,
    input  sample_t fill,
    output pair_t   frame
);
    sample_t valid_s, spare_s;

    always_comb begin
        valid_s = head.left;
        spare_s = cfg.mono_dup ? head.left : fill;
        if (!have_data) begin
            frame = '0;
        end else if (!cfg.mono_en) begin
            frame = head;
        end else if (cfg.mono_first) begin
            frame = '{left: valid_s, right: spare_s};
        end else begin
            frame = '{left: spare_s, right: valid_s};
        end
    end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  cfg_t  cfg,
    input  logic  have_data,
    input  pair_t next_pair,
    output logic  pop,
    output logic  bclk,
    output logic  ws,
    output logic  sd
);
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CLK_DIV / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

    logic             waiting;
    logic [CNT_W-1:0] cnt;
    chan_e            ch, nch, after_ch;
    idx_t             idx, nidx, last;
    pair_t            cur;
    logic             tick, frame_end, may_launch, launch;

    always_comb begin
        last       = last_idx(cfg.wide_slot);
        tick       = !waiting && (cnt == CNT_LAST);
        frame_end  = (ch == CH_RIGHT) && (idx == last);
        may_launch = have_data || !cfg.halt_on_empty;
        launch     = start && may_launch && (waiting || (tick && frame_end));
        pop        = launch && have_data;
        nidx       = (idx == last) ? '0 : idx_t'(idx + 1'b1);
        nch        = (idx == last) ? other_chan(ch) : ch;
        after_ch   = (nidx == last) ? other_chan(nch) : nch;
    end

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            waiting <= 1'b1;
            cnt     <= '0;
            bclk    <= 1'b0;
            ws      <= ws_level(CH_LEFT, cfg.ws_invert);
            sd      <= 1'b0;
            ch      <= CH_LEFT;
            idx     <= '0;
            cur     <= '0;
        end else if (launch) begin
            cur     <= next_pair;
            ch      <= CH_LEFT;
            idx     <= '0;
            sd      <= slot_bit(next_pair.left, '0, cfg);
            ws      <= ws_level(CH_LEFT, cfg.ws_invert);
            waiting <= 1'b0;
            cnt     <= '0;
            bclk    <= 1'b0;
        end else if (!waiting) begin
            if (tick) begin
                cnt  <= '0;
                bclk <= 1'b0;
                if (frame_end) begin
                    waiting <= 1'b1;
                end else begin
                    ch  <= nch;
                    idx <= nidx;
                    sd  <= slot_bit((nch == CH_LEFT) ? cur.left : cur.right, nidx, cfg);
                    ws  <= ws_level(after_ch, cfg.ws_invert);
                end
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == CNT_HALF) bclk <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2s_serial_tx.sv
module i2s_serial_tx
    import i2s_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                ws_invert,
    input  logic                lsb_first,
    input  logic                left_justify,
    input  logic                wide_slot,
    input  logic                mono_en,
    input  logic                mono_first,
    input  logic                mono_dup,
    input  logic                halt_on_empty,
    input  logic [SAMPLE_W-1:0] mono_fill,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    output logic                fifo_full,
    output logic                bclk,
    output logic                ws,
    output logic                sd
);
    localparam int PAIR_W = $bits(pair_t);

    cfg_t              cfg;
    pair_t             wr_pair, head, frame;
    logic [PAIR_W-1:0] head_bits;
    logic              fifo_empty, pop;

    assign cfg = '{ws_invert: ws_invert, lsb_first: lsb_first,
                   left_justify: left_justify, wide_slot: wide_slot,
                   mono_en: mono_en, mono_first: mono_first,
                   mono_dup: mono_dup, halt_on_empty: halt_on_empty};
    assign wr_pair = '{left: wr_left, right: wr_right};
    assign head    = pair_t'(head_bits);

    i2s_tx_fifo #(.WIDTH(PAIR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_pair),
        .rd_en(pop), .rd_data(head_bits), .empty(fifo_empty), .full(fifo_full)
    );

    i2s_tx_framer u_framer (
        .cfg(cfg), .have_data(!fifo_empty), .head(head),
        .fill(mono_fill), .frame(frame)
    );

    i2s_tx_serializer #(.CLK_DIV(CLK_DIV)) u_ser (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg),
        .have_data(!fifo_empty), .next_pair(frame), .pop(pop),
        .bclk(bclk), .ws(ws), .sd(sd)
    );
endmodule

// File: rtl/i2s_serial_tx_chk.sv
module i2s_serial_tx_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic ws_invert,
    input logic bclk,
    input logic ws,
    input logic sd,
    input logic pop,
    input logic fifo_empty,
    input logic fifo_full
);
    // R1: idle outputs right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!bclk && !sd && !fifo_full));

    // R3: word select moves only while bclk is low
    a_r3_ws_low_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws) |-> !bclk);

    // R3: data moves only while bclk is low
    a_r3_sd_low_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd) |-> !bclk);

    // R11: a pair leaves the queue only with ws at the left level
    a_r11_pop_on_left: assert property (@(posedge clk) disable iff (rst)
        pop |-> (ws == ws_invert));

    // R11: never consume from an empty queue
    a_r11_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !fifo_empty);

    // R12: a full queue stays full until a pair is consumed
    a_r12_full_holds: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !pop) |=> fifo_full);

    // R13: no bit clock without start
    a_r13_idle_no_clock: assert property (@(posedge clk) disable iff (rst)
        !start |=> !bclk);
endmodule

bind i2s_serial_tx i2s_serial_tx_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .ws_invert(ws_invert),
    .bclk(bclk), .ws(ws), .sd(sd), .pop(pop),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full)
);

// File: tb/i2s_serial_tx_tb.sv
module i2s_serial_tx_tb;
    localparam int DEPTH = 4;
    localparam int DIV   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ws_invert = 1'b0, lsb_first = 1'b0, left_justify = 1'b0, wide_slot = 1'b0;
    logic mono_en = 1'b0, mono_first = 1'b0, mono_dup = 1'b0, halt_on_empty = 1'b1;
    logic [23:0] mono_fill = '0;
    logic wr_en = 1'b0;
    logic [23:0] wr_left = '0, wr_right = '0;
    logic fifo_full, bclk, ws, sd;

    always #2.5 clk = ~clk;

    i2s_serial_tx #(.FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .start(start), .ws_invert(ws_invert),
        .lsb_first(lsb_first), .left_justify(left_justify), .wide_slot(wide_slot),
        .mono_en(mono_en), .mono_first(mono_first), .mono_dup(mono_dup),
        .halt_on_empty(halt_on_empty), .mono_fill(mono_fill), .wr_en(wr_en),
        .wr_left(wr_left), .wr_right(wr_right), .fifo_full(fifo_full),
        .bclk(bclk), .ws(ws), .sd(sd)
    );

    int n_chk = 0, n_fail = 0;
    logic [1:0] exp_q[$];
    string cur_req = "R1";
    bit strict = 1'b1;
    int cyc = 0, last_rise = 0, min_gap = 1000, rises = 0;
    logic prev_b = 1'b0;
    bit done = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // model of one transmitted bit: requirements R4, R5, R6
    function automatic logic model_bit(input logic [23:0] s, input int i);
        int p;
        if (wide_slot && left_justify && i >= 24) return 1'b0;
        if (wide_slot && !left_justify) begin
            if (i < 8) return 1'b0;
            p = i - 8;
        end else begin
            p = i;
        end
        return lsb_first ? s[p] : s[23-p];
    endfunction

    // expected (ws, sd) per bit for one frame: R2, R3
    task automatic add_frame(input logic [23:0] l, input logic [23:0] r);
        int len;
        len = wide_slot ? 32 : 24;
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < len; i++) begin
                logic wch;
                wch = (i == len - 1) ? (c == 0) : (c == 1);
                exp_q.push_back({wch ^ ws_invert, model_bit((c == 0) ? l : r, i)});
            end
        end
    endtask

    task automatic write_fifo(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        wr_en = 1'b1; wr_left = l; wr_right = r;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: write a pair and queue what it must produce (R7, R8)
    task automatic push(input logic [23:0] l, input logic [23:0] r);
        logic [23:0] o;
        write_fifo(l, r);
        if (!mono_en) add_frame(l, r);
        else begin
            o = mono_dup ? l : mono_fill;
            if (mono_first) add_frame(l, o);
            else add_frame(o, l);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        strict = 1'b1; min_gap = 1000; last_rise = 0;
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, {cur_req, " drain"}, exp_q.size(), 0);
        repeat (4 * DIV) @(negedge clk);
    endtask

    // monitor: decode at rising bclk, compare with scoreboard
    always @(negedge clk) begin
        cyc++;
        if (bclk && !prev_b) begin
            rises++;
            if (last_rise > 0 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
            last_rise = cyc;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk({ws, sd} == e, {cur_req, " ws/sd bit"}, {30'd0, ws, sd}, {30'd0, e});
            end else if (strict) begin
                chk(1'b0, {cur_req, " unexpected bit"}, {30'd0, ws, sd}, 0);
            end
        end
        prev_b = bclk;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        int r0;
        do_reset();
        // R1 reset state
        cur_req = "R1";
        chk(bclk == 1'b0, "R1 bclk", bclk, 0);
        chk(sd == 1'b0, "R1 sd", sd, 0);
        chk(ws == ws_invert, "R1 ws left level", ws, ws_invert);
        chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);

        // stereo, MSB first, 24-clock slots
        cur_req = "R2 R4 R5 stereo msb";
        push(24'h800001, 24'h123456);
        push(24'hFEDCBA, 24'h0F0F0F);
        push(24'h000001, 24'h800000);
        r0 = rises;
        repeat (40) @(negedge clk);
        chk(rises == r0, "R13 no clock before start", rises, r0);
        start = 1'b1;
        drain();
        chk(min_gap == DIV, "R14 bclk period", min_gap, DIV);

        // inverted ws, LSB first, 32-clock left-justified
        ws_invert = 1'b1; lsb_first = 1'b1; wide_slot = 1'b1; left_justify = 1'b1;
        do_reset();
        cur_req = "R2 R4 R6 lsb left-justified";
        @(negedge clk);
        chk(ws == 1'b1, "R2 idle ws inverted", ws, 1);
        push(24'hC00003, 24'h5A1234);
        push(24'h000080, 24'hABCDEF);
        start = 1'b1;
        drain();

        // right-justified, MSB first
        ws_invert = 1'b0; lsb_first = 1'b0; left_justify = 1'b0;
        do_reset();
        cur_req = "R5 R6 right-justified";
        push(24'hFFFFFF, 24'h000001);
        push(24'h8000AA, 24'h7FFF55);
        start = 1'b1;
        drain();

        // mono in left slot, fill word in right; wr_right ignored
        wide_slot = 1'b0; mono_en = 1'b1; mono_first = 1'b1; mono_dup = 1'b0;
        mono_fill = 24'hA5A5A5;
        do_reset();
        cur_req = "R7 R8 mono first fill";
        push(24'h112233, 24'h5A5A5A);
        push(24'hF00F00, 24'hFFFFFF);
        start = 1'b1;
        drain();

        // mono in right slot, duplicated
        mono_first = 1'b0; mono_dup = 1'b1;
        do_reset();
        cur_req = "R7 R8 mono second dup";
        push(24'h13579B, 24'h000000);
        push(24'h2468AC, 24'h999999);
        start = 1'b1;
        drain();

        // halt on empty, then resume with aligned pairs
        mono_en = 1'b0;
        do_reset();
        cur_req = "R9 R11 stall resume";
        push(24'hA00005, 24'h50000A);
        start = 1'b1;
        drain();
        r0 = rises;
        repeat (100) @(negedge clk);
        chk(rises == r0, "R9 clocks halted", rises, r0);
        chk(bclk == 1'b0, "R9 bclk low", bclk, 0);
        chk(ws == ws_invert, "R9 ws held left", ws, ws_invert);
        push(24'h123123, 24'h456456);
        push(24'h789789, 24'hABCABC);
        drain();

        // no halt: zero frame on underflow
        halt_on_empty = 1'b0;
        do_reset();
        cur_req = "R10 zero frame";
        strict = 1'b0;
        push(24'hFFFFFF, 24'hFFFFFF);
        add_frame(24'h0, 24'h0);
        start = 1'b1;
        drain();
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk(bclk == 1'b0, "R13 stop returns idle", bclk, 0);
        r0 = rises;
        repeat (50) @(negedge clk);
        chk(rises == r0, "R13 no clock after stop", rises, r0);

        // full queue drops extra writes
        halt_on_empty = 1'b1;
        do_reset();
        cur_req = "R12 overflow";
        push(24'h000011, 24'h000022);
        push(24'h000033, 24'h000044);
        push(24'h000055, 24'h000066);
        push(24'h000077, 24'h000088);
        chk(fifo_full == 1'b1, "R12 full at depth", fifo_full, 1);
        write_fifo(24'hDEADBE, 24'hEFBEEF);
        chk(fifo_full == 1'b1, "R12 still full", fifo_full, 1);
        start = 1'b1;
        drain();
        repeat (200) @(negedge clk);

        // reset drops queued pairs
        do_reset();
        cur_req = "R1 queue cleared";
        write_fifo(24'h111111, 24'h222222);
        write_fifo(24'h333333, 24'h444444);
        do_reset();
        start = 1'b1;
        r0 = rises;
        repeat (100) @(negedge clk);
        chk(rises == r0, "R1 queue cleared by reset", rises, r0);
        start = 1'b0;

        finish_up();
    end
endmodule